// File: doc/BRIEF.md
# Asynchronous Byte-Lane SRAM Sequencer

This block sits between an internal request bus and an external asynchronous static RAM of 131,072 sixteen-bit words. Each request carries a read/write flag, a 17-bit word address, a 2-bit byte mask and write data. It is accepted with a valid/ready handshake and turned into a strobe sequence on the memory's active-low chip select, output enable, write enable and two byte-lane selects. The block drives the data bus through a separate drive-enable output; the pad buffer itself is outside it. For reads, it samples the bus and returns the word on a one-cycle response strobe.

Every wait phase is a whole number of clock cycles. That number is derived from a clock-period parameter and the memory's minimum timing values, so the same code runs at any clock rate. Writes end with write enable rising while chip select and the lane selects are still low. A read is always followed by a quiet gap before the block drives the bus again. A request with an empty mask completes in the next cycle and touches no memory pin.

Top module: `sram16_ctrl`

## Requirements
- R1: During and after reset, the chip select, output enable, write enable and both lane selects are high, the bus drive enable is low, `req_ready` is high and `rsp_valid` is low.
- R2: A request is taken only in a cycle where `req_valid` and `req_ready` are both high. For a non-empty mask, `req_ready` is low from the next cycle until the access ends, including any turnaround. That is WP+2 cycles for a write and RD+TA cycles for a read.
- R3: A phase for time t lasts max(1, ceil(t / CLK_PERIOD_NS)) cycles, written cyc(t). WP is the larger of cyc(max(pulse, address-to-end, data-setup)) and cyc(write cycle) - 2. RD is cyc(max(address access, output-enable access, lane access)). TA is cyc(release time).
- R4: A write runs as follows. One setup cycle has address, chip select, lane selects and bus drive active, with write enable high. Write enable is then low for exactly WP cycles. One hold cycle follows with write enable high and everything else still active. Write enable is never low unless chip select is low, a lane select is low and the bus is driven, and the address and data stay stable while it is low.
- R5: Mask bit 0 controls the low lane select and data bits [7:0]. Mask bit 1 controls the high lane select and bits [15:8]. A single-lane write leaves the other byte of the stored word unchanged.
- R6: A read holds chip select and output enable low with write enable high for exactly RD cycles. The bus is sampled at the clock edge that ends the last of these cycles. `rsp_valid` pulses in the next cycle, and `rsp_rdata` holds the sampled lanes with every unmasked lane forced to zero.
- R7: Output enable and bus drive are never active together. Bus drive is not enabled until output enable has been high for at least TA cycles. A write presented right after a read first drives the bus TA+1 cycles after output enable rises.
- R8: A request with mask 0 asserts no memory strobe, keeps `req_ready` high and pulses `rsp_valid` in the next cycle with `rsp_rdata` equal to zero.
- R9: A write completes with `rsp_valid` pulsing in the cycle `req_ready` returns high, WP+3 cycles after acceptance, with `rsp_rdata` equal to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_mask | input | 2 | Byte mask, bit 0 low byte, bit 1 high byte |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-cycle completion strobe |
| rsp_rdata | output | 16 | Read data, masked lanes zero |
| mem_addr | output | 17 | Memory address |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_lb_n | output | 1 | Low lane select, active low |
| mem_ub_n | output | 1 | High lane select, active low |
| mem_dq_out | output | 16 | Data toward the memory |
| mem_dq_oe | output | 1 | Bus drive enable for the pad buffer |
| mem_dq_in | input | 16 | Data from the memory |

## Verification
A corrupted state register or phase counter shows at the ports within one access. The first thing to move is the strobe pulse width or the `req_ready` low time, which the bench counts cycle by cycle against its own cyc() arithmetic. A wrong lane decode shows up as a stored byte that should not have changed, or as a lane that should read zero but does not, at the next read of that word. A shortened turnaround shows as a bus-drive rise less than TA+1 cycles after output enable rises, in the first write after any read.

// File: rtl/sram16_pkg.sv
package sram16_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_WSET = 3'd1,
    ST_WPUL = 3'd2,
    ST_WHLD = 3'd3,
    ST_RACC = 3'd4,
    ST_TURN = 3'd5
  } seq_state_e;

  // Whole cycles covering t_ns, never fewer than one.
  function automatic int unsigned phase_cycles(int unsigned t_ns, int unsigned clk_ns);
    int unsigned c;
    c = (t_ns + clk_ns - 1) / clk_ns;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // Low time of write enable: covers its own minimums and stretches the
  // whole write (setup + pulse + hold) to the write cycle minimum.
  function automatic int unsigned wr_pulse_cycles(int unsigned t_pwe, int unsigned t_aw,
                                                  int unsigned t_sd, int unsigned t_wc,
                                                  int unsigned clk_ns);
    int unsigned p;
    int unsigned w;
    p = phase_cycles(max3(t_pwe, t_aw, t_sd), clk_ns);
    w = phase_cycles(t_wc, clk_ns);
    return (w > p + 2) ? (w - 2) : p;
  endfunction

endpackage

// File: rtl/sram16_phase_timer.sv
module sram16_phase_timer #(
  parameter int unsigned CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

  AST_TMR_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && expired) |=> expired);  // R3
endmodule

// File: rtl/sram16_lanes.sv
module sram16_lanes #(
  parameter int unsigned LANES  = 2,
  parameter int unsigned LANE_W = 8
) (
  input  logic                     active,
  input  logic [LANES-1:0]         sel_mask,
  input  logic [LANES-1:0]         cap_mask,
  input  logic [LANES*LANE_W-1:0]  rd_raw,
  output logic [LANES-1:0]         sel_n,
  output logic [LANES*LANE_W-1:0]  rd_gated
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign sel_n[g] = ~(active & sel_mask[g]);
    assign rd_gated[g*LANE_W +: LANE_W] = cap_mask[g] ? rd_raw[g*LANE_W +: LANE_W] : '0;
  end
endmodule

// File: rtl/sram16_ctrl.sv
module sram16_ctrl
  import sram16_pkg::*;
#(
  parameter int unsigned AW            = 17,
  parameter int unsigned LANE_W        = 8,
  parameter int unsigned LANES         = 2,
  parameter int unsigned CLK_PERIOD_NS = 10,
  parameter int unsigned T_WC_NS       = 12,
  parameter int unsigned T_PWE_NS      = 10,
  parameter int unsigned T_AW_NS       = 10,
  parameter int unsigned T_SD_NS       = 7,
  parameter int unsigned T_AA_NS       = 12,
  parameter int unsigned T_DOE_NS      = 6,
  parameter int unsigned T_DBE_NS      = 6,
  parameter int unsigned T_REL_NS      = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_write,
  input  logic [AW-1:0]           req_addr,
  input  logic [LANES-1:0]        req_mask,
  input  logic [LANES*LANE_W-1:0] req_wdata,
  output logic                    rsp_valid,
  output logic [LANES*LANE_W-1:0] rsp_rdata,
  output logic [AW-1:0]           mem_addr,
  output logic                    mem_ce_n,
  output logic                    mem_oe_n,
  output logic                    mem_we_n,
  output logic                    mem_lb_n,
  output logic                    mem_ub_n,
  output logic [LANES*LANE_W-1:0] mem_dq_out,
  output logic                    mem_dq_oe,
  input  logic [LANES*LANE_W-1:0] mem_dq_in
);
  localparam int unsigned DW    = LANES * LANE_W;
  localparam int unsigned N_WP  = wr_pulse_cycles(T_PWE_NS, T_AW_NS, T_SD_NS, T_WC_NS, CLK_PERIOD_NS);
  localparam int unsigned N_RD  = phase_cycles(max3(T_AA_NS, T_DOE_NS, T_DBE_NS), CLK_PERIOD_NS);
  localparam int unsigned N_TA  = phase_cycles(T_REL_NS, CLK_PERIOD_NS);
  localparam int unsigned N_MAX = max3(N_WP, N_RD, N_TA);
  localparam int unsigned CW    = $clog2(N_MAX + 1);

  seq_state_e       state, state_d;
  logic             op_write;
  logic [LANES-1:0] op_mask, mask_d;
  logic [LANES-1:0] sel_n_d, sel_n_q;
  logic [DW-1:0]    rd_gated;
  logic             accept, accept_empty, accept_real;
  logic             tmr_load, tmr_done;
  logic [CW-1:0]    tmr_val;
  logic             sel_active_d, rd_capture, wr_finish;

  // named internal events
  assign accept       = req_valid && req_ready;
  assign accept_empty = accept && (req_mask == '0);
  assign accept_real  = accept && (req_mask != '0);
  assign rd_capture   = (state == ST_RACC) && tmr_done;
  assign wr_finish    = (state == ST_WHLD);

  always_comb begin
    state_d = state;
    unique case (state)
      ST_IDLE: if (accept_real) state_d = req_write ? ST_WSET : ST_RACC;
      ST_WSET: state_d = ST_WPUL;
      ST_WPUL: if (tmr_done) state_d = ST_WHLD;
      ST_WHLD: state_d = ST_IDLE;
      ST_RACC: if (tmr_done) state_d = ST_TURN;
      ST_TURN: if (tmr_done) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    tmr_load = (state_d != state) &&
               (state_d == ST_WPUL || state_d == ST_RACC || state_d == ST_TURN);
    unique case (state_d)
      ST_WPUL: tmr_val = CW'(N_WP - 1);
      ST_RACC: tmr_val = CW'(N_RD - 1);
      default: tmr_val = CW'(N_TA - 1);
    endcase
  end

  sram16_phase_timer #(.CW(CW)) i_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .expired(tmr_done)
  );

  assign mask_d       = accept ? req_mask : op_mask;
  assign sel_active_d = (state_d == ST_WSET) || (state_d == ST_WPUL) ||
                        (state_d == ST_WHLD) || (state_d == ST_RACC);

  sram16_lanes #(.LANES(LANES), .LANE_W(LANE_W)) i_lanes (
    .active(sel_active_d), .sel_mask(mask_d), .cap_mask(op_mask),
    .rd_raw(mem_dq_in), .sel_n(sel_n_d), .rd_gated(rd_gated)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      op_write   <= 1'b0;
      op_mask    <= '0;
      mem_addr   <= '0;
      mem_dq_out <= '0;
      mem_ce_n   <= 1'b1;
      mem_oe_n   <= 1'b1;
      mem_we_n   <= 1'b1;
      sel_n_q    <= '1;
      mem_dq_oe  <= 1'b0;
      req_ready  <= 1'b1;
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
    end else begin
      state <= state_d;
      if (accept) begin
        op_write   <= req_write;
        op_mask    <= req_mask;
        mem_addr   <= req_addr;
        mem_dq_out <= req_wdata;
      end
      mem_ce_n  <= ~sel_active_d;
      mem_oe_n  <= ~(state_d == ST_RACC);
      mem_we_n  <= ~(state_d == ST_WPUL);
      sel_n_q   <= sel_n_d;
      mem_dq_oe <= (state_d == ST_WSET) || (state_d == ST_WPUL) || (state_d == ST_WHLD);
      req_ready <= (state_d == ST_IDLE);
      rsp_valid <= accept_empty || wr_finish || rd_capture;
      if (rd_capture)                       rsp_rdata <= rd_gated;
      else if (accept_empty || wr_finish)   rsp_rdata <= '0;
    end
  end

  assign mem_lb_n = sel_n_q[0];
  assign mem_ub_n = sel_n_q[LANES-1];

  // ---------------- checking ----------------
  int unsigned we_low_run, oe_high_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_low_run  <= 0;
      oe_high_run <= 1000;
    end else begin
      we_low_run  <= mem_we_n ? 0 : ((we_low_run < 1000) ? we_low_run + 1 : we_low_run);
      oe_high_run <= !mem_oe_n ? 0 : ((oe_high_run < 1000) ? oe_high_run + 1 : oe_high_run);
    end
  end

  AST_WE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_ce_n && (!mem_lb_n || !mem_ub_n) && mem_dq_oe && op_write));  // R4
  AST_WE_HOLDS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && $past(!mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_dq_out)));  // R4
  AST_WE_PULSE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_low_run == N_WP));  // R3
  AST_OE_EXCLUDES_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (!mem_dq_oe && mem_we_n));  // R7
  AST_TURNAROUND_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> (oe_high_run >= N_TA));  // R7
  AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe));  // R8
endmodule

// File: tb/test_sram16_ctrl.sv
module test_sram16_ctrl;
  localparam int CLK_T  = 10;
  localparam int CLK_NS = 4;
  localparam int T_WC = 12, T_PWE = 10, T_AW = 10, T_SD = 7;
  localparam int T_AA = 12, T_DOE = 6, T_DBE = 6, T_REL = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [16:0] req_addr = '0;
  logic [1:0]  req_mask = '0;
  logic [15:0] req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [15:0] rsp_rdata;
  logic [16:0] mem_addr;
  logic        mem_ce_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n, mem_dq_oe;
  logic [15:0] mem_dq_out, mem_dq_in;

  always #(CLK_T/2) clk = ~clk;

  sram16_ctrl #(.CLK_PERIOD_NS(CLK_NS), .T_WC_NS(T_WC), .T_PWE_NS(T_PWE), .T_AW_NS(T_AW),
                .T_SD_NS(T_SD), .T_AA_NS(T_AA), .T_DOE_NS(T_DOE), .T_DBE_NS(T_DBE),
                .T_REL_NS(T_REL)) i_sram16_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_mask(req_mask), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in));

  // ---- memory model: 64 words, indexed by the low address bits ----
  logic [15:0] model [64];
  always @(posedge mem_we_n or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) model[i] <= 16'(i * 16'h0101) ^ 16'h3C00;
    end else if (!mem_ce_n && mem_dq_oe) begin
      if (!mem_lb_n) model[mem_addr[5:0]][7:0]  <= mem_dq_out[7:0];
      if (!mem_ub_n) model[mem_addr[5:0]][15:8] <= mem_dq_out[15:8];
    end
  end
  assign mem_dq_in = (!mem_ce_n && !mem_oe_n && mem_we_n) ?
                     {mem_ub_n ? 8'hE7 : model[mem_addr[5:0]][15:8],
                      mem_lb_n ? 8'h7E : model[mem_addr[5:0]][7:0]} : 16'hBEEF;

  int n_chk = 0, n_bad = 0;
  bit done_flag = 0;

  task automatic check(input string req, input int act, input int exp, input string what);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // own ceiling: smallest n >= 1 with n*CLK_NS >= t
  function automatic int cyc(input int t);
    int n = 1;
    while (n * CLK_NS < t) n++;
    return n;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  int e_wp, e_rd, e_ta;
  logic [15:0] refm [64];

  // ---- protocol monitor ----
  int oe_hi_run = 1000, min_gap = 1000;
  int v_we = 0, v_oe = 0, v_stab = 0, v_addr = 0;
  logic prev_we_n = 1, prev_dq_oe = 0;
  logic [16:0] prev_addr; logic [15:0] prev_dout;
  logic [16:0] cur_addr = '0;
  always @(negedge clk) if (rst_n) begin
    if (!mem_we_n && (mem_ce_n || (mem_lb_n && mem_ub_n) || !mem_dq_oe)) v_we++;
    if (!mem_oe_n && mem_dq_oe) v_oe++;
    if (!mem_we_n && !prev_we_n && (mem_addr != prev_addr || mem_dq_out != prev_dout)) v_stab++;
    if (!mem_ce_n && mem_addr != cur_addr) v_addr++;
    if (mem_dq_oe && !prev_dq_oe && oe_hi_run < min_gap) min_gap = oe_hi_run;
    oe_hi_run  = !mem_oe_n ? 0 : oe_hi_run + 1;
    prev_we_n  = mem_we_n; prev_dq_oe = mem_dq_oe;
    prev_addr  = mem_addr; prev_dout  = mem_dq_out;
  end

  task automatic run_req(input bit wr, input logic [16:0] a, input logic [1:0] m,
                         input logic [15:0] wd);
    int rsp_k = 0, low = 0, wel = 0, oel = 0, cel = 0, lanebad = 0;
    logic [15:0] rd = '0;
    logic [15:0] lm;
    lm = {{8{m[1]}}, {8{m[0]}}};
    check("R2", req_ready, 1, "ready before request");
    cur_addr  = a;
    req_valid = 1; req_write = wr; req_addr = a; req_mask = m; req_wdata = wd;
    @(negedge clk);
    req_valid = 0;
    for (int k = 1; k <= 40; k++) begin
      if (rsp_valid) begin rsp_k = k; rd = rsp_rdata; end
      if (!req_ready) low++;
      if (!mem_we_n)  wel++;
      if (!mem_oe_n)  oel++;
      if (!mem_ce_n) begin
        cel++;
        if (mem_lb_n != !m[0] || mem_ub_n != !m[1]) lanebad++;
      end
      if (rsp_k != 0 && req_ready) break;
      @(negedge clk);
    end
    check("R5", lanebad, 0, "lane select vs mask");
    if (m == 2'b00) begin
      check("R8", rsp_k, 1, "empty-mask response cycle");
      check("R8", low, 0, "empty-mask ready low cycles");
      check("R8", cel + wel + oel, 0, "empty-mask strobes");
      check("R8", rd, 0, "empty-mask data");
    end else if (wr) begin
      check("R9", rsp_k, e_wp + 3, "write response cycle");
      check("R2", low, e_wp + 2, "write ready low cycles");
      check("R3", wel, e_wp, "write enable low cycles");
      check("R4", cel, e_wp + 2, "write chip select cycles");
      check("R9", rd, 0, "write response data");
      refm[a[5:0]] = (refm[a[5:0]] & ~lm) | (wd & lm);
    end else begin
      check("R6", rsp_k, e_rd + 1, "read response cycle");
      check("R2", low, e_rd + e_ta, "read ready low cycles");
      check("R3", oel, e_rd, "output enable low cycles");
      check("R6", rd, refm[a[5:0]] & lm, "read data");
    end
  endtask

  initial begin
    e_wp = mx(cyc(mx(T_PWE, mx(T_AW, T_SD))), cyc(T_WC) - 2);
    e_rd = cyc(mx(T_AA, mx(T_DOE, T_DBE)));
    e_ta = cyc(T_REL);
    for (int i = 0; i < 64; i++) refm[i] = 16'(i * 16'h0101) ^ 16'h3C00;
    repeat (3) @(negedge clk);
    // R1: reset values while held
    check("R1", {mem_ce_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n}, 5'b11111, "enables in reset");
    check("R1", {mem_dq_oe, req_ready, rsp_valid}, 3'b010, "drive/ready/rsp in reset");
    rst_n = 1;
    @(negedge clk);
    check("R1", {mem_ce_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n}, 5'b11111, "enables after reset");
    check("R1", {mem_dq_oe, req_ready, rsp_valid}, 3'b010, "drive/ready/rsp after reset");
    // sweep: addresses x masks, write then full read then masked read
    for (int a = 0; a < 8; a++) begin
      for (int m = 0; m < 4; m++) begin
        logic [16:0] ad;
        ad = 17'((a << 11) | (a * 5));
        run_req(1'b1, ad, 2'(m), 16'(16'h1000 * a + m * 16'h0111) ^ 16'hC3A5);
        run_req(1'b0, ad, 2'b11, 16'h0);  // R5: other byte unchanged
        run_req(1'b0, ad, 2'(m), 16'h0);
      end
    end
    // R8: empty-mask read straight after a real read
    run_req(1'b0, 17'h0_0007, 2'b01, 16'h0);
    run_req(1'b0, 17'h1_FFC7, 2'b00, 16'h0);
    repeat (2) @(negedge clk);
    check("R7", min_gap, e_ta + 1, "turnaround gap before drive");
    check("R7", v_oe, 0, "output enable with bus drive");
    check("R4", v_we, 0, "write enable without select/drive");
    check("R4", v_stab, 0, "address/data change during write pulse");
    check("R4", v_addr, 0, "address while selected");
    if (!done_flag) begin
      done_flag = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_T * 150000);
    if (!done_flag) begin
      done_flag = 1;
      n_chk++; n_bad++;
      $display("FAIL R2 watchdog: actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule